// File: doc/BRIEF.md
# Memory-Mapped External Interrupt Aggregator

This block gathers sixteen external interrupt request lines from the board and folds them into one interrupt output for the processor. Each line first passes through a two-flop synchroniser. A level register then records the last synchronised state of every line, and a change on a line counts as an event. An event on an enabled line replaces the pending register with that line's one-hot code, and the single output takes the line's new level. An event on a disabled line only updates the level register.

Software reaches the block through a byte-addressed register window. The bus has an address, write data, a write strobe, a read strobe and registered read data. The window holds an enable-mask register, a pending set/clear register and ten plain storage registers for board functions. Only bits that match the constant 0xFEEFF can be written in the mask and pending registers.

Top module: `irq_merge_regs`

## Requirements
- R1: After reset the mask, pending, level and storage registers are zero, `irq_out` is low and `bus_rdata` is zero.
- R2: The mask register is at offset 0xC0 and the pending register at 0xD0. A write to either stores the write data ANDed with 0xFEEFF, and a later read returns that value.
- R3: The storage registers at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 each return the last full 32-bit value written to them.
- R4: A read from any other offset returns zero. A write to any other offset leaves every register unchanged.
- R5: `bus_rdata` is loaded on the rising edge where `bus_re` is high and holds its value while `bus_re` is low.
- R6: A change applied to `irq_in` acts on the pending register and `irq_out` at the third rising clock edge after it is applied, and not earlier.
- R7: When line n changes and mask bit n is set, the pending register becomes 1<<n and `irq_out` takes the new level of line n.
- R8: When line n changes and mask bit n is clear, the pending register and `irq_out` stay unchanged. Lines 8 and 12 can never be enabled, because mask bits 8 and 12 are outside 0xFEEFF.
- R9: The level register follows every line, enabled or not. Setting a mask bit for a line that changed while it was disabled does not raise an event.
- R10: When several enabled lines change in the same cycle, the lowest-numbered line sets both the pending register and `irq_out`.
- R11: A bus write to the pending register in the same cycle as an enabled event wins. The pending register takes the written value, the event is discarded and `irq_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | External interrupt request lines, asynchronous |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Merged interrupt toward the processor |

## Verification
The bench drives several lines at once to check that the lowest-numbered line wins; a design that took the highest line, or ORed the codes together, would read back the wrong pending value. It toggles line 8, which can never be enabled, and changes a line while masked and then unmasks it; a design that stopped tracking levels of masked lines would fire a spurious event at that point. It makes a pending write land in the same cycle as an enabled event; a design that let the event win would show a one-hot code and a moved output. It also samples the output one edge before the third edge, which catches a synchroniser that is missing or one stage too deep.

// File: rtl/irq_merge_regs.sv
module irq_merge_regs #(
  parameter int NLINES = 16,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [DW-1:0] WMASK = 32'h000F_EEFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_out
);
  localparam int NSCR = 10;
  localparam logic [AW-1:0] MASK_OFF = AW'('hC0);
  localparam logic [AW-1:0] PEND_OFF = AW'('hD0);

  function automatic logic [AW-1:0] scr_off(input int i);
    case (i)
      0: scr_off = AW'('h10);
      1: scr_off = AW'('h14);
      2: scr_off = AW'('h40);
      3: scr_off = AW'('h60);
      4: scr_off = AW'('h80);
      5: scr_off = AW'('h84);
      6: scr_off = AW'('h88);
      7: scr_off = AW'('h90);
      8: scr_off = AW'('hE0);
      default: scr_off = AW'('hE4);
    endcase
  endfunction

  logic [DW-1:0] mask_q, pend_q;
  logic [NLINES-1:0] sync_a, sync_q, lvl_q;
  logic [DW-1:0] scr_q [NSCR];
  logic [NSCR-1:0] scr_hit;
  logic [DW-1:0] scr_rd;

  wire mask_wr = bus_we && bus_addr == MASK_OFF;
  wire pend_wr = bus_we && bus_addr == PEND_OFF;

  wire [NLINES-1:0] evt = (sync_q ^ lvl_q) & mask_q[NLINES-1:0];
  wire [NLINES-1:0] win = evt & (~evt + NLINES'(1));

  genvar g;
  generate
    for (g = 0; g < NSCR; g++) begin : g_scr
      assign scr_hit[g] = bus_addr == scr_off(g);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) scr_q[g] <= '0;
        else if (bus_we && scr_hit[g]) scr_q[g] <= bus_wdata;
    end
  endgenerate

  always_comb begin
    scr_rd = '0;
    for (int i = 0; i < NSCR; i++)
      if (scr_hit[i]) scr_rd = scr_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_q <= '0;
      lvl_q  <= '0;
    end else begin
      sync_a <= irq_in;
      sync_q <= sync_a;
      lvl_q  <= sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      pend_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= bus_wdata & WMASK;
      if (pend_wr) begin
        pend_q <= bus_wdata & WMASK;
      end else if (|evt) begin
        pend_q  <= DW'(win);
        irq_out <= |(win & sync_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) begin
      if (bus_addr == MASK_OFF) bus_rdata <= mask_q;
      else if (bus_addr == PEND_OFF) bus_rdata <= pend_q;
      else bus_rdata <= scr_rd;
    end
  end
endmodule

// File: rtl/irq_merge_regs_chk.sv
module irq_merge_regs_chk #(
  parameter int NLINES = 16,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [DW-1:0] WMASK = 32'h000F_EEFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DW-1:0]     bus_rdata,
  input logic              irq_out,
  input logic [DW-1:0]     mask_q,
  input logic [DW-1:0]     pend_q,
  input logic [NLINES-1:0] sync_q,
  input logic [NLINES-1:0] lvl_q
);
  wire pend_wr = bus_we && bus_addr == AW'('hD0);
  wire any_evt = |((sync_q ^ lvl_q) & mask_q[NLINES-1:0]);
  wire undec = !(bus_addr inside {AW'('h10), AW'('h14), AW'('h40), AW'('h60), AW'('h80),
                 AW'('h84), AW'('h88), AW'('h90), AW'('hE0), AW'('hE4), AW'('hC0), AW'('hD0)});

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_out && pend_q == '0 && mask_q == '0));
  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('hC0)) |=> mask_q == ($past(bus_wdata) & WMASK));
  // R4
  undecoded_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && undec) |=> bus_rdata == '0);
  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
  // R8
  quiet_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_evt && !pend_wr) |=> ($stable(irq_out) && $stable(pend_q)));
  // R7
  onehot_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_evt && !pend_wr) |=> $countones(pend_q) == 1);
  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> (pend_q == ($past(bus_wdata) & WMASK) && $stable(irq_out)));
endmodule

bind irq_merge_regs irq_merge_regs_chk #(.NLINES(NLINES), .DW(DW), .AW(AW), .WMASK(WMASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_out(irq_out), .mask_q(mask_q),
  .pend_q(pend_q), .sync_q(sync_q), .lvl_q(lvl_q));

// File: tb/irq_merge_regs_tb_top.sv
module irq_merge_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] irq_in = '0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 0, bus_re = 0;
  logic [31:0] bus_rdata;
  logic irq_out;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic re_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_merge_regs dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_out(irq_out));

  always @(posedge clk) re_seen <= bus_re;

  always @(negedge clk) if (re_seen && exp_q.size() > 0) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h", t, bus_rdata, e);
    end
  end

  task automatic chk_out(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s irq_out actual %b expected %b", t, irq_out, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_addr = a; bus_re = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_re = 0;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk); irq_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [10] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};
    repeat (3) @(negedge clk);
    chk_out(0, "R1");
    checks++;
    if (bus_rdata !== 0) begin errors++; $display("FAIL R1 rdata actual %h expected 0", bus_rdata); end
    rst_n = 1;
    rd(8'hC0, 0, "R1 mask");
    rd(8'hD0, 0, "R1 pend");
    rd(8'h10, 0, "R1 scratch");
    for (int i = 0; i < 10; i++) wr(offs[i], 32'hA500_0000 | (i * 32'h0101_0F0F));
    for (int i = 0; i < 10; i++) rd(offs[i], 32'hA500_0000 | (i * 32'h0101_0F0F), "R3");
    wr(8'h20, 32'hDEAD_BEEF);
    wr(8'hC4, 32'hFFFF_FFFF);
    rd(8'h20, 0, "R4 undecoded");
    rd(8'hC4, 0, "R4 undecoded");
    rd(8'h14, 32'hA500_0000 | 32'h0101_0F0F, "R4 neighbour");
    rd(8'hC0, 0, "R4 mask untouched");
    // R5: hold value while bus_re low
    @(negedge clk); bus_addr = 8'h10;
    repeat (2) @(negedge clk);
    checks++;
    if (bus_rdata !== 0) begin errors++; $display("FAIL R5 rdata actual %h expected 0", bus_rdata); end
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, 32'h000F_EEFF, "R2 mask");
    wr(8'hD0, 32'hFFFF_FFFF);
    rd(8'hD0, 32'h000F_EEFF, "R2 pend");
    wr(8'hD0, 0);
    set_lines(16'h0020);
    chk_out(1, "R7 rise");
    rd(8'hD0, 32'h20, "R7 pend");
    set_lines(16'h0000);
    chk_out(0, "R7 fall");
    set_lines(16'h0048);
    chk_out(1, "R10");
    rd(8'hD0, 32'h08, "R10 pend lowest");
    set_lines(16'h0148);
    chk_out(1, "R8 line8");
    rd(8'hD0, 32'h08, "R8 line8 pend");
    wr(8'hC0, 0);
    set_lines(16'h0140);
    chk_out(1, "R8 masked");
    rd(8'hD0, 32'h08, "R8 masked pend");
    wr(8'hC0, 32'h000F_EEFF);
    repeat (3) @(negedge clk);
    chk_out(1, "R9");
    rd(8'hD0, 32'h08, "R9 pend");
    set_lines(16'h0100);
    chk_out(0, "R7 line6 fall");
    rd(8'hD0, 32'h40, "R7 line6 pend");
    // R11: pending write lands on the event edge
    @(negedge clk); irq_in = 16'h0104;
    @(negedge clk);
    @(negedge clk); bus_addr = 8'hD0; bus_wdata = 32'h0000_0300; bus_we = 1;
    @(negedge clk); bus_we = 0;
    repeat (2) @(negedge clk);
    chk_out(0, "R11");
    rd(8'hD0, 32'h200, "R11 pend");
    // R6: third edge
    @(negedge clk); irq_in = 16'h0106;
    @(negedge clk);
    @(negedge clk);
    chk_out(0, "R6 early");
    @(negedge clk);
    chk_out(1, "R6 third edge");
    rd(8'hD0, 32'h02, "R6 pend");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule